// File: doc/BRIEF.md
# Two-Level Interrupt Status Hub

This block gathers the event strobes of a radio protocol engine into one pending-interrupt register and drives a single active-high system interrupt line from it. Eight top-level bits each latch one class of event. Two of them are summaries: one stands for "a transmission has begun" and the other for "a transmission has ended". Each is fed from its own sub-status register, which records the individual cause, and each of those causes passes through a mask before it can raise its summary bit. A one-bit message-check record notes whether the latest whole received message failed its CRC.

The host reads the status registers over a small register port. It acknowledges pending bits by writing ones to a clear location. Clearing a summary bit also empties the sub-status register behind it. An event that arrives in the same cycle as the clear of its own bit keeps that bit set, so no event is lost. The protocol engines that produce the strobes sit outside this block.

Top module: `irq_hub`

## Requirements
- R1: After reset all status registers read 0, the start mask reads 0x7F, the end mask reads 0x3F and `sys_irq` is low.
- R2: A strobe on `plain_evt_i` bit 7, 4, 3, 2, 1 or 0 sets the same bit of the top status register (address 0) on the next clock edge, and the bit stays set until cleared. Bits 6 and 5 of `plain_evt_i` have no effect.
- R3: A strobe on `start_evt_i[k]` sets bit k of the start sub-status register (address 2) whatever the mask. It sets top bit 6 only when bit k of the start mask (address 3) is 1.
- R4: A strobe on `end_evt_i[k]` sets bit k of the end sub-status register (address 4) whatever the mask. It sets top bit 5 only when bit k of the end mask (address 5) is 1.
- R5: When `plain_evt_i[2]` strobes, bit 7 of the message-check register (address 6) takes the value of `msg_fail_i`: 1 for a failed check, 0 for a passed one. Bits 6..0 of that register read 0.
- R6: A write to address 1 clears every top status bit whose written bit is 1 and leaves every other bit unchanged.
- R7: Clearing top bit 6 empties the start sub-status register. Clearing top bit 5 empties the end sub-status register. Clearing top bit 2 resets the message-check bit.
- R8: When an event for a bit arrives in the same cycle as a clear of that bit, the bit is set after the edge. This holds for top bits and for sub-status bits.
- R9: `sys_irq` is high exactly when at least one top status bit is set.
- R10: The mask registers store the written value limited to their width (7 bits for start, 6 bits for end). Reads of addresses 1 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| plain_evt_i | input | 8 | Event strobes for top bits that have no masked cause register |
| msg_fail_i | input | 1 | CRC result that goes with the message strobe (plain bit 2) |
| start_evt_i | input | START_W | Transmit-start cause strobes |
| end_evt_i | input | END_W | Transmit-end cause strobes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| sys_irq | output | 1 | System interrupt, high while any top bit is pending |

## Verification
The clear path and event capture can act on the same bit in one cycle. The bench provokes this by strobing an event together with a write to address 1 that names the event's bit. This is done for a plain top bit and for a start cause, whose summary and sub-status bit are cleared in that same write. The bench expects the bit, and the sub-status cause where there is one, to read as set afterwards. Sweeps over every plain pattern and every mask-and-cause pair check capture and masking against values worked out from the masks.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int START_W = 7,
  parameter int END_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         plain_evt_i,
  input  logic               msg_fail_i,
  input  logic [START_W-1:0] start_evt_i,
  input  logic [END_W-1:0]   end_evt_i,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               sys_irq
);
  localparam logic [2:0] A_TOP   = 3'd0;
  localparam logic [2:0] A_CLR   = 3'd1;
  localparam logic [2:0] A_SSTAT = 3'd2;
  localparam logic [2:0] A_SMASK = 3'd3;
  localparam logic [2:0] A_ESTAT = 3'd4;
  localparam logic [2:0] A_EMASK = 3'd5;
  localparam logic [2:0] A_MSG   = 3'd6;
  localparam int B_START = 6;
  localparam int B_END   = 5;
  localparam int B_MSG   = 2;

  logic [7:0]         top_q;
  logic [START_W-1:0] start_q, start_mask_q;
  logic [END_W-1:0]   end_q, end_mask_q;
  logic               msg_fail_q;

  wire [7:0] clr = (reg_we && reg_addr == A_CLR) ? reg_wdata : 8'h00;
  wire [7:0] top_set = {plain_evt_i[7],
                        |(start_evt_i & start_mask_q),
                        |(end_evt_i & end_mask_q),
                        plain_evt_i[4:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q        <= '0;
      start_q      <= '0;
      end_q        <= '0;
      msg_fail_q   <= 1'b0;
      start_mask_q <= '1;
      end_mask_q   <= '1;
    end else begin
      top_q   <= (top_q & ~clr) | top_set;
      start_q <= (clr[B_START] ? '0 : start_q) | start_evt_i;
      end_q   <= (clr[B_END] ? '0 : end_q) | end_evt_i;
      if (plain_evt_i[B_MSG])  msg_fail_q <= msg_fail_i;
      else if (clr[B_MSG])     msg_fail_q <= 1'b0;
      if (reg_we && reg_addr == A_SMASK) start_mask_q <= reg_wdata[START_W-1:0];
      if (reg_we && reg_addr == A_EMASK) end_mask_q   <= reg_wdata[END_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      A_TOP:   reg_rdata = top_q;
      A_SSTAT: reg_rdata[START_W-1:0] = start_q;
      A_SMASK: reg_rdata[START_W-1:0] = start_mask_q;
      A_ESTAT: reg_rdata[END_W-1:0] = end_q;
      A_EMASK: reg_rdata[END_W-1:0] = end_mask_q;
      A_MSG:   reg_rdata[7] = msg_fail_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign sys_irq = |top_q;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int START_W = 7,
  parameter int END_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         plain_evt_i,
  input logic [START_W-1:0] start_evt_i,
  input logic [START_W-1:0] start_mask,
  input logic               reg_we,
  input logic [2:0]         reg_addr,
  input logic [7:0]         reg_wdata,
  input logic [7:0]         top,
  input logic [START_W-1:0] start_sub,
  input logic               sys_irq
);
  wire clr_wr = reg_we && reg_addr == 3'd1;

  p_plain_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    plain_evt_i[7] |=> top[7]);

  p_masked_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt_i & start_mask) != '0 |=> top[6]);

  p_clear_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && reg_wdata[7] && !plain_evt_i[7] |=> !top[7]);

  p_sub_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && reg_wdata[6] && start_evt_i == '0 |=> start_sub == '0);

  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && reg_wdata[0] && plain_evt_i[0] |=> top[0]);

  p_irq_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_irq && !clr_wr |=> sys_irq);
endmodule

bind irq_hub irq_hub_chk #(.START_W(START_W), .END_W(END_W)) u_irq_hub_chk (
  .clk(clk), .rst_n(rst_n), .plain_evt_i(plain_evt_i), .start_evt_i(start_evt_i),
  .start_mask(start_mask_q), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .top(top_q), .start_sub(start_q), .sys_irq(sys_irq)
);

// File: tb/test_irq_hub.sv
module test_irq_hub;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] plain_evt_i = '0;
  logic msg_fail_i = 1'b0;
  logic [6:0] start_evt_i = '0;
  logic [5:0] end_evt_i = '0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic sys_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_hub i_irq_hub (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] p, input logic [6:0] s, input logic [5:0] e,
                      input logic f, input logic we, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    plain_evt_i = p; start_evt_i = s; end_evt_i = e; msg_fail_i = f;
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    plain_evt_i = '0; start_evt_i = '0; end_evt_i = '0; msg_fail_i = 1'b0;
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(8'h00, 7'h00, 6'h00, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  initial begin
    logic [7:0] v, exp;
    #(CLK_PERIOD*3 + 2); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(3'd0, v); chk("R1 top", v, 8'h00);
    rd(3'd2, v); chk("R1 start sub", v, 8'h00);
    rd(3'd3, v); chk("R1 start mask", v, 8'h7F);
    rd(3'd4, v); chk("R1 end sub", v, 8'h00);
    rd(3'd5, v); chk("R1 end mask", v, 8'h3F);
    rd(3'd6, v); chk("R1 msg", v, 8'h00);
    chk("R1 irq", {7'b0, sys_irq}, 8'h00);

    // R2 / R9 every plain pattern
    for (int p = 0; p < 256; p++) begin
      wr(3'd1, 8'hFF);
      step(p[7:0], 7'h00, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00);
      exp = p[7:0] & 8'h9F;
      rd(3'd0, v); chk("R2 plain capture", v, exp);
      chk("R9 irq level", {7'b0, sys_irq}, {7'b0, exp != 8'h00});
    end
    step(8'h00, 7'h00, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00);
    rd(3'd0, v); chk("R2 bit held", v, 8'h9F);

    // R3 every start mask against every single cause
    for (int m = 0; m < 128; m++)
      for (int c = 0; c < 7; c++) begin
        wr(3'd1, 8'hFF);
        wr(3'd3, m[7:0]);
        step(8'h00, 7'(1 << c), 6'h00, 1'b0, 1'b0, 3'd0, 8'h00);
        rd(3'd0, v); chk("R3 start summary", v, {1'b0, m[c], 6'b0});
        rd(3'd2, v); chk("R3 start cause", v, 8'(1 << c));
      end

    // R4 every end mask against every single cause
    for (int m = 0; m < 64; m++)
      for (int c = 0; c < 6; c++) begin
        wr(3'd1, 8'hFF);
        wr(3'd5, m[7:0]);
        step(8'h00, 7'h00, 6'(1 << c), 1'b0, 1'b0, 3'd0, 8'h00);
        rd(3'd0, v); chk("R4 end summary", v, {2'b0, m[c], 5'b0});
        rd(3'd4, v); chk("R4 end cause", v, 8'(1 << c));
      end

    // R10 mask width
    wr(3'd3, 8'hFF); rd(3'd3, v); chk("R10 start mask", v, 8'h7F);
    wr(3'd5, 8'hFF); rd(3'd5, v); chk("R10 end mask", v, 8'h3F);
    rd(3'd1, v); chk("R10 addr1 read", v, 8'h00);
    rd(3'd7, v); chk("R10 addr7 read", v, 8'h00);

    // R5 message check
    for (int f = 0; f < 2; f++) begin
      wr(3'd1, 8'hFF);
      step(8'h04, 7'h00, 6'h00, f[0], 1'b0, 3'd0, 8'h00);
      rd(3'd6, v); chk("R5 msg check", v, {f[0], 7'b0});
    end

    // R6 / R7 partial clears
    wr(3'd1, 8'hFF);
    step(8'h9F, 7'h05, 6'h09, 1'b1, 1'b0, 3'd0, 8'h00);
    wr(3'd1, 8'h40);
    rd(3'd0, v); chk("R6 clear bit6 only", v, 8'hBF);
    rd(3'd2, v); chk("R7 start sub emptied", v, 8'h00);
    rd(3'd4, v); chk("R7 end sub kept", v, 8'h09);
    wr(3'd1, 8'h20);
    rd(3'd4, v); chk("R7 end sub emptied", v, 8'h00);
    rd(3'd6, v); chk("R7 msg kept", v, 8'h80);
    wr(3'd1, 8'h04);
    rd(3'd6, v); chk("R7 msg reset", v, 8'h00);
    rd(3'd0, v); chk("R6 remaining", v, 8'h9B);
    wr(3'd1, 8'h00);
    rd(3'd0, v); chk("R6 zero write", v, 8'h9B);

    // R8 event against clear in the same cycle
    step(8'h01, 7'h00, 6'h00, 1'b0, 1'b1, 3'd1, 8'h01);
    rd(3'd0, v); chk("R8 plain bit survives", v, 8'h9B);
    step(8'h00, 7'h02, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00);
    step(8'h00, 7'h10, 6'h00, 1'b0, 1'b1, 3'd1, 8'h40);
    rd(3'd0, v); chk("R8 summary survives", v, 8'hDB);
    rd(3'd2, v); chk("R8 only new cause", v, 8'h10);
    wr(3'd1, 8'hFF);
    rd(3'd0, v); chk("R6 all cleared", v, 8'h00);
    chk("R9 irq low", {7'b0, sys_irq}, 8'h00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule